// File: doc/BRIEF.md
# Speaker and Refresh Status Port

This block is a single byte-wide I/O port of the kind found in PC-style system logic. Software writes it to open or close the gate of an external interval-timer channel and to enable the speaker data path. Software reads it to see those two stored controls, the live output of that timer channel, and a refresh indicator.

The block sits behind a simple strobe bus. An upstream decoder asserts `port_sel` when the access targets this port. `wr_stb` and `rd_stb` qualify writes and reads. The timer channel itself lives outside the block: its output arrives on `timer_out`, and the stored gate leaves on `timer_gate`.

The refresh indicator does not run from a clock. It inverts once for each read access to the port. This lets polling code see a changing bit without a real refresh circuit behind it.

Top module: `spkr_status_port`

## Requirements
- R1: Reset (synchronous, active high) clears the timer gate, the speaker enable and the refresh indicator, and re-arms read detection.
- R2: A selected write (`port_sel` and `wr_stb` high at a clock edge) loads data bit 0 into `timer_gate`, visible from the next cycle.
- R3: A selected write loads data bit 1 into `spk_enable`, visible from the next cycle.
- R4: During a selected read, `rd_data` bit 0 equals the current gate level and bit 1 equals the current speaker enable.
- R5: During a selected read, `rd_data` bit 5 equals `timer_out` in the same cycle, with no register in the path.
- R6: During a selected read, `rd_data` bit 4 carries the refresh indicator. The indicator inverts at the clock edge that ends the first cycle of each selected read strobe, so the value just read is the value before inversion.
- R7: During a selected read, `rd_data` bits 2, 3, 6 and 7 are zero.
- R8: Strobes without `port_sel` change neither the gate, the speaker enable nor the refresh indicator.
- R9: Whenever no selected read is in progress, `rd_data` is all zero.
- R10: A selected read strobe held high for several cycles inverts the refresh indicator only once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_sel | input | 1 | Access targets this port |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| timer_out | input | 1 | Live output of the timer channel |
| rd_data | output | 8 | Read data, combinational |
| timer_gate | output | 1 | Gate level for the timer channel |
| spk_enable | output | 1 | Speaker data enable |

## Verification
On every cycle, the bound checker checks these properties:
- the write path into the gate and the speaker enable;
- that the stored controls hold when no selected write occurs;
- the same-cycle passthrough of the timer output;
- the zero reserved bits and the zero bus when idle;
- that the refresh indicator inverts exactly on the first cycle of a selected read and holds otherwise.

Some behaviour shows only in the bench's scenarios, which compare every cycle against a behavioural model:
- the visible readback order of the refresh bit across sequences of separate, held and unselected reads;
- a write and a read in the same cycle;
- clearing by a reset in the middle of operation.

// File: rtl/spkr_pkg.sv
package spkr_pkg;
  localparam int PORT_W   = 8;
  localparam int GATE_BIT = 0;
  localparam int SPK_BIT  = 1;
  localparam int REFR_BIT = 4;
  localparam int TMR_BIT  = 5;
endpackage

// File: rtl/spkr_ctl_reg.sv
module spkr_ctl_reg (
  input  logic clk,
  input  logic rst,
  input  logic wr_fire,
  input  logic gate_in,
  input  logic spk_in,
  output logic gate_q,
  output logic spk_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      spk_q  <= 1'b0;
    end else if (wr_fire) begin
      gate_q <= gate_in;
      spk_q  <= spk_in;
    end
  end
endmodule

// File: rtl/spkr_refresh_tog.sv
module spkr_refresh_tog #(
  parameter bit EDGE_ONLY = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_qual,
  output logic rd_fire,
  output logic tog_q
);
  generate
    if (EDGE_ONLY) begin : g_edge
      logic seen_q;
      always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= rd_qual;
      end
      assign rd_fire = rd_qual && !seen_q;
    end else begin : g_level
      assign rd_fire = rd_qual;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          tog_q <= 1'b0;
    else if (rd_fire) tog_q <= ~tog_q;
  end
endmodule

// File: rtl/spkr_rd_mux.sv
module spkr_rd_mux
  import spkr_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic         rd_qual,
  input  logic         gate_q,
  input  logic         spk_q,
  input  logic         tog_q,
  input  logic         timer_out,
  output logic [W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_qual) begin
      rd_data[GATE_BIT] = gate_q;
      rd_data[SPK_BIT]  = spk_q;
      rd_data[REFR_BIT] = tog_q;
      rd_data[TMR_BIT]  = timer_out;
    end
  end
endmodule

// File: rtl/spkr_status_port.sv
module spkr_status_port
  import spkr_pkg::*;
#(
  parameter int DATA_W    = PORT_W,
  parameter bit EDGE_ONLY = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_sel,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              timer_out,
  output logic [DATA_W-1:0] rd_data,
  output logic              timer_gate,
  output logic              spk_enable
);
  logic wr_qual, rd_qual, rd_fire, tog_q;
  logic unused_wbits;

  assign wr_qual      = port_sel && wr_stb;
  assign rd_qual      = port_sel && rd_stb;
  assign unused_wbits = ^wr_data;

  spkr_ctl_reg u_ctl (
    .clk     (clk),
    .rst     (rst),
    .wr_fire (wr_qual),
    .gate_in (wr_data[GATE_BIT]),
    .spk_in  (wr_data[SPK_BIT]),
    .gate_q  (timer_gate),
    .spk_q   (spk_enable)
  );

  spkr_refresh_tog #(.EDGE_ONLY(EDGE_ONLY)) u_tog (
    .clk     (clk),
    .rst     (rst),
    .rd_qual (rd_qual),
    .rd_fire (rd_fire),
    .tog_q   (tog_q)
  );

  spkr_rd_mux #(.W(DATA_W)) u_mux (
    .rd_qual   (rd_qual),
    .gate_q    (timer_gate),
    .spk_q     (spk_enable),
    .tog_q     (tog_q),
    .timer_out (timer_out),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/spkr_status_chk.sv
module spkr_status_chk
  import spkr_pkg::*;
#(
  parameter int DATA_W = PORT_W
) (
  input logic              clk,
  input logic              rst,
  input logic              port_sel,
  input logic              wr_stb,
  input logic              rd_stb,
  input logic [DATA_W-1:0] wr_data,
  input logic              timer_out,
  input logic [DATA_W-1:0] rd_data,
  input logic              timer_gate,
  input logic              spk_enable,
  input logic              rd_fire,
  input logic              tog_q
);
  assert_gate_load_R2: assert property (@(posedge clk) disable iff (rst)
    (port_sel && wr_stb) |=> (timer_gate == $past(wr_data[GATE_BIT])));

  assert_spk_load_R3: assert property (@(posedge clk) disable iff (rst)
    (port_sel && wr_stb) |=> (spk_enable == $past(wr_data[SPK_BIT])));

  assert_timer_live_R5: assert property (@(posedge clk) disable iff (rst)
    (port_sel && rd_stb) |-> (rd_data[TMR_BIT] == timer_out));

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_data[7:6] == 2'b00) && (rd_data[3:2] == 2'b00));

  assert_ctl_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(port_sel && wr_stb) |=> ($stable(timer_gate) && $stable(spk_enable)));

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !(port_sel && rd_stb) |-> (rd_data == '0));

  assert_refresh_flip_R6: assert property (@(posedge clk) disable iff (rst)
    rd_fire |=> (tog_q != $past(tog_q)));

  assert_refresh_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |=> $stable(tog_q));

  assert_fire_needs_sel_R8: assert property (@(posedge clk) disable iff (rst)
    rd_fire |-> (port_sel && rd_stb));
endmodule

bind spkr_status_port spkr_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .port_sel   (port_sel),
  .wr_stb     (wr_stb),
  .rd_stb     (rd_stb),
  .wr_data    (wr_data),
  .timer_out  (timer_out),
  .rd_data    (rd_data),
  .timer_gate (timer_gate),
  .spk_enable (spk_enable),
  .rd_fire    (rd_fire),
  .tog_q      (tog_q)
);

// File: tb/sim_spkr_status_port.sv
`timescale 1ns/1ps
module sim_spkr_status_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       port_sel = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0, timer_out = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       timer_gate, spk_enable;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit m_gate, m_spk, m_tog, m_prev;

  always #4 clk = ~clk;

  spkr_status_port u0 (
    .clk(clk), .rst(rst), .port_sel(port_sel), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wr_data(wr_data), .timer_out(timer_out), .rd_data(rd_data),
    .timer_gate(timer_gate), .spk_enable(spk_enable)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, compare, then advance model at posedge
  task automatic cyc(input bit r, input bit s, input bit w, input bit rd,
                     input logic [7:0] d, input bit t, input string tag);
    logic [7:0] exp_rd;
    bit fire;
    @(negedge clk);
    rst = r; port_sel = s; wr_stb = w; rd_stb = rd; wr_data = d; timer_out = t;
    #1;
    exp_rd = 8'h00;
    if (s && rd) exp_rd = {2'b00, t, m_tog, 2'b00, m_spk, m_gate};
    if (!r) chk({tag, " rd_data"}, rd_data, exp_rd);
    chk({tag, " gate"}, {7'b0, timer_gate}, {7'b0, m_gate});
    chk({tag, " spk"},  {7'b0, spk_enable}, {7'b0, m_spk});
    @(posedge clk);
    fire = s && rd && !m_prev;
    if (r) begin
      m_gate = 0; m_spk = 0; m_tog = 0; m_prev = 0;
    end else begin
      if (s && w) begin m_gate = d[0]; m_spk = d[1]; end
      if (fire) m_tog = ~m_tog;
      m_prev = s && rd;
    end
  endtask

  initial begin : watchdog
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_gate = 0; m_spk = 0; m_tog = 0; m_prev = 0;
    // R1: reset state
    cyc(1, 0, 0, 0, 8'h00, 0, "R1");
    cyc(1, 0, 0, 0, 8'h00, 0, "R1");
    cyc(0, 1, 0, 1, 8'h00, 0, "R1 R7 initial read");
    cyc(0, 0, 0, 0, 8'h00, 0, "R9 idle");
    // R2 R3: write both bits
    cyc(0, 1, 1, 0, 8'h03, 0, "R2 R3 write 03");
    cyc(0, 0, 0, 0, 8'h00, 0, "R2 R3 after write");
    // R4 R5 R6: reads with timer high/low
    cyc(0, 1, 0, 1, 8'h00, 1, "R4 R5 R6 read1");
    cyc(0, 0, 0, 0, 8'h00, 1, "R9 gap");
    cyc(0, 1, 0, 1, 8'h00, 0, "R4 R5 R6 read2");
    cyc(0, 0, 0, 0, 8'h00, 0, "R9 gap");
    // R7: reserved bits written high, gate off, speaker on
    cyc(0, 1, 1, 0, 8'hFE, 1, "R7 write FE");
    cyc(0, 1, 0, 1, 8'hFF, 1, "R7 R4 read");
    cyc(0, 0, 0, 0, 8'h00, 0, "R9 gap");
    // R8: unselected write and read
    cyc(0, 0, 1, 0, 8'h01, 0, "R8 unsel write");
    cyc(0, 0, 0, 1, 8'h00, 1, "R8 R9 unsel read");
    cyc(0, 0, 1, 1, 8'h00, 1, "R8 unsel both");
    cyc(0, 1, 0, 1, 8'h00, 0, "R8 R6 readback");
    cyc(0, 0, 0, 0, 8'h00, 0, "R9 gap");
    // R10: held read strobe
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 1, 8'h00, i[0], "R10 held read");
    cyc(0, 0, 0, 0, 8'h00, 0, "R9 gap");
    cyc(0, 1, 0, 1, 8'h00, 1, "R10 R6 after held");
    cyc(0, 0, 0, 0, 8'h00, 0, "R9 gap");
    // write and read in one cycle: read shows old state
    cyc(0, 1, 1, 1, 8'h01, 0, "R4 R2 same cycle");
    cyc(0, 0, 0, 0, 8'h00, 0, "R2 settle");
    cyc(0, 1, 0, 1, 8'h00, 1, "R4 R6 readback");
    // select dropped while strobe held re-arms detection
    cyc(0, 0, 0, 1, 8'h00, 0, "R8 sel low");
    cyc(0, 1, 0, 1, 8'h00, 0, "R6 rearm");
    // R1: mid-operation reset
    cyc(1, 0, 0, 0, 8'h00, 0, "R1 mid reset");
    cyc(0, 0, 0, 0, 8'h00, 0, "R1 after reset");
    cyc(0, 1, 0, 1, 8'h00, 0, "R1 read after reset");
    cyc(0, 0, 0, 0, 8'h00, 0, "R9 end");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule